// File: doc/BRIEF.md
# Idle Entry and Wake Controller

This block decides when the processor core sleeps and how it comes back. Software writes a 1 into the idle bit of a small power-control register. The core clock enable then drops while the peripheral clock enable stays high, so timers, serial logic and the interrupt sources keep running. RAM and special-function state are untouched because the core simply stops advancing.

Idle ends in one of two ways. The first is an interrupt that is both pending and enabled, with the global enable also set. It resumes the core on the next machine-cycle boundary. The second is a hardware reset. On that path the core is allowed to run on for a parameterised number of machine cycles (default two) before the internal reset sequence takes over. Throughout that run-on window the block withholds write permission from internal RAM but keeps granting it to the port pins. Once the window closes, a reset-sequence flag is raised and held until the reset input is released.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After the power-on reset `rstN`, the core and peripheral clock enables are high, RAM and port writes are allowed, `resetSeqActive` is low and the power-control register reads 0.
- R2: A write (`ctrlWrite`) whose bit 0 is 1 sets bit 0 of `pwrCtrlQ` after one clock. `cpuClkEn` falls one clock later, and `periphClkEn` stays high.
- R3: Control-register writes are ignored while the core is idle or while the idle bit is already set. A run-time write with bit 0 equal to 0 leaves the core running.
- R4: Interrupt line i is a wake source only when `irqPend[i]`, `irqEn[i]` and `irqGlobalEn` are all 1.
- R5: A wake by interrupt takes effect only on a clock where `mcTick` is 1. `cpuClkEn` is high after that edge and hardware clears bit 0 of `pwrCtrlQ`. Without a tick the core stays idle.
- R6: A valid interrupt seen during idle is remembered, so it still wakes the core at a later tick after the lines have dropped.
- R7: `hwReset` during idle raises `cpuClkEn` after one clock and clears the idle bit. From then until the window closes, `ramWrAllow` is 0 while `portWrAllow` stays 1.
- R8: The run-on window closes on the WIN_MC-th `mcTick` after it opens. Clocks without a tick do not shorten it. `resetSeqActive` then rises, and `ramWrAllow`, `portWrAllow` and `periphClkEn` go low.
- R9: While `resetSeqActive` is high and `hwReset` is 0, the block returns to normal running on the next clock with all permissions high.
- R10: `hwReset` while running (not idle) raises `resetSeqActive` after one clock with no run-on window.
- R11: If `hwReset` and a wake-capable interrupt with a tick arrive in the same idle cycle, the reset path (run-on window) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| hwReset | input | 1 | Hardware reset request, active high, level |
| mcTick | input | 1 | One-clock pulse marking a machine-cycle boundary |
| ctrlWrite | input | 1 | Write strobe for the power-control register |
| ctrlWrData | input | CTRL_W | Write data; bit 0 is the idle request |
| irqPend | input | NUM_IRQ | Interrupt pending flags |
| irqEn | input | NUM_IRQ | Per-line interrupt enables |
| irqGlobalEn | input | 1 | Global interrupt enable |
| cpuClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| ramWrAllow | output | 1 | Internal RAM write permission |
| portWrAllow | output | 1 | Port pin write permission |
| resetSeqActive | output | 1 | Internal reset sequence in control |
| pwrCtrlQ | output | CTRL_W | Power-control register contents |

## Verification
The checker watches every cycle for these relations:
- the core clock enable falls only while the idle bit is set;
- it rises only after a tick or a reset;
- an idle core with no tick and no reset stays idle;
- RAM writes are never blocked without port writes passing and the core running;
- the reset sequence starts only from a reset or from a tick closing the window;
- the reset sequence leaves as soon as reset drops.

Other properties can only be shown by the bench's scenarios:
- which combinations of pending, enable and global bits wake the core;
- that a short interrupt is latched;
- that the window lasts exactly the configured number of ticks regardless of tickless clocks;
- that reset beats a coincident wake.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  // Bit of the power-control register that requests idle.
  localparam int IDLE_BIT = 0;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_WINDOW = 2'd2,
    PM_RSTSEQ = 2'd3
  } pmState_t;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic ctrlLoad;   // load the power-control register
    logic idleClr;    // hardware clear of the idle bit and wake latch
    logic wakeHold;   // capture a valid wake request
    logic winClr;     // restart the run-on window counter
    logic winStep;    // count one machine cycle of the window
  } pmStrobe_t;

endpackage

// File: rtl/idle_wake_datapath.sv
module idle_wake_datapath
  import idle_wake_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int CTRL_W  = 8,
  parameter int WIN_MC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pmStrobe_t          strobe,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               irqGlobalEn,
  output logic [CTRL_W-1:0]  ctrlQ,
  output logic               idleBit,
  output logic               wakeReq,
  output logic               winLast
);

  localparam int CNT_W = (WIN_MC > 1) ? $clog2(WIN_MC) : 1;
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WIN_MC - 1);

  logic [NUM_IRQ-1:0] lineWake;
  logic               wakeNow;
  logic               wakeLatch;
  logic [CNT_W-1:0]   winCnt;

  // Per-line qualification of interrupt sources.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
      assign lineWake[gi] = irqPend[gi] & irqEn[gi];
    end
  endgenerate

  assign wakeNow = irqGlobalEn & (|lineWake);
  assign wakeReq = wakeNow | wakeLatch;
  assign idleBit = ctrlQ[IDLE_BIT];
  assign winLast = (winCnt == WIN_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (strobe.idleClr) begin
      ctrlQ[IDLE_BIT] <= 1'b0;
    end else if (strobe.ctrlLoad) begin
      ctrlQ <= ctrlWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeLatch <= 1'b0;
    end else if (strobe.idleClr) begin
      wakeLatch <= 1'b0;
    end else if (strobe.wakeHold && wakeNow) begin
      wakeLatch <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.winClr) begin
      winCnt <= '0;
    end else if (strobe.winStep) begin
      winCnt <= winCnt + 1'b1;
    end
  end

endmodule

// File: rtl/idle_wake_control.sv
module idle_wake_control
  import idle_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hwReset,
  input  logic      mcTick,
  input  logic      ctrlWrite,
  input  logic      idleBit,
  input  logic      wakeReq,
  input  logic      winLast,
  output pmStrobe_t strobe,
  output logic      cpuClkEn,
  output logic      periphClkEn,
  output logic      ramWrAllow,
  output logic      portWrAllow,
  output logic      resetSeqActive
);

  pmState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      PM_RUN: begin
        if (hwReset) begin
          stateNxt       = PM_RSTSEQ;
          strobe.idleClr = 1'b1;
        end else begin
          strobe.ctrlLoad = ctrlWrite && !idleBit;
          if (idleBit) stateNxt = PM_IDLE;
        end
      end
      PM_IDLE: begin
        strobe.wakeHold = 1'b1;
        if (hwReset) begin
          stateNxt       = PM_WINDOW;
          strobe.idleClr = 1'b1;
          strobe.winClr  = 1'b1;
        end else if (mcTick && wakeReq) begin
          stateNxt       = PM_RUN;
          strobe.idleClr = 1'b1;
        end
      end
      PM_WINDOW: begin
        if (mcTick) begin
          if (winLast) stateNxt = PM_RSTSEQ;
          else         strobe.winStep = 1'b1;
        end
      end
      PM_RSTSEQ: begin
        if (!hwReset) stateNxt = PM_RUN;
      end
      default: stateNxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_RUN;
    else       state <= stateNxt;
  end

  assign cpuClkEn       = (state != PM_IDLE);
  assign periphClkEn    = (state != PM_RSTSEQ);
  assign ramWrAllow     = (state == PM_RUN) || (state == PM_IDLE);
  assign portWrAllow    = (state != PM_RSTSEQ);
  assign resetSeqActive = (state == PM_RSTSEQ);

endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_wake_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int CTRL_W  = 8,
  parameter int WIN_MC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hwReset,
  input  logic               mcTick,
  input  logic               ctrlWrite,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               irqGlobalEn,
  output logic               cpuClkEn,
  output logic               periphClkEn,
  output logic               ramWrAllow,
  output logic               portWrAllow,
  output logic               resetSeqActive,
  output logic [CTRL_W-1:0]  pwrCtrlQ
);

  pmStrobe_t strobe;
  logic      idleBit;
  logic      wakeReq;
  logic      winLast;

  idle_wake_control u_control (
    .clk            (clk),
    .rstN           (rstN),
    .hwReset        (hwReset),
    .mcTick         (mcTick),
    .ctrlWrite      (ctrlWrite),
    .idleBit        (idleBit),
    .wakeReq        (wakeReq),
    .winLast        (winLast),
    .strobe         (strobe),
    .cpuClkEn       (cpuClkEn),
    .periphClkEn    (periphClkEn),
    .ramWrAllow     (ramWrAllow),
    .portWrAllow    (portWrAllow),
    .resetSeqActive (resetSeqActive)
  );

  idle_wake_datapath #(
    .NUM_IRQ (NUM_IRQ),
    .CTRL_W  (CTRL_W),
    .WIN_MC  (WIN_MC)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ctrlWrData  (ctrlWrData),
    .irqPend     (irqPend),
    .irqEn       (irqEn),
    .irqGlobalEn (irqGlobalEn),
    .ctrlQ       (pwrCtrlQ),
    .idleBit     (idleBit),
    .wakeReq     (wakeReq),
    .winLast     (winLast)
  );

endmodule

// File: rtl/idle_wake_ctrl_checker.sv
module idle_wake_ctrl_checker (
  input logic clk,
  input logic rstN,
  input logic hwReset,
  input logic mcTick,
  input logic cpuClkEn,
  input logic periphClkEn,
  input logic ramWrAllow,
  input logic portWrAllow,
  input logic resetSeqActive,
  input logic idleBitQ
);

  // R2: the core only stops while the idle bit is set
  assert_sleep_needs_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuClkEn) |-> ($past(idleBitQ) && idleBitQ));

  // R5: the core restarts only at a tick or through reset
  assert_wake_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> ($past(mcTick) || $past(hwReset)));

  // R3: an idle core without tick or reset stays idle with its bit set
  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && !hwReset && !mcTick) |=> (!cpuClkEn && idleBitQ));

  // R7: RAM blocked outside the reset sequence means run-on window
  assert_window_ports_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWrAllow && !resetSeqActive) |-> (cpuClkEn && portWrAllow && !idleBitQ));

  // R8: the reset sequence starts from reset while running or from a closing tick
  assert_seq_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetSeqActive) |-> ($past(ramWrAllow) ? $past(hwReset) : $past(mcTick)));

  // R9: the reset sequence ends once reset drops
  assert_seq_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resetSeqActive && !hwReset) |=> !resetSeqActive);

  // R2: peripherals keep their clock outside the reset sequence
  assert_periph_alive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !resetSeqActive |-> (periphClkEn && portWrAllow));

endmodule

bind idle_wake_ctrl idle_wake_ctrl_checker u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .hwReset        (hwReset),
  .mcTick         (mcTick),
  .cpuClkEn       (cpuClkEn),
  .periphClkEn    (periphClkEn),
  .ramWrAllow     (ramWrAllow),
  .portWrAllow    (portWrAllow),
  .resetSeqActive (resetSeqActive),
  .idleBitQ       (pwrCtrlQ[0])
);

// File: tb/idle_wake_ctrl_tb.sv
`timescale 1ns/1ps
module idle_wake_ctrl_tb;

  localparam int NUM_IRQ = 4;
  localparam int CTRL_W  = 8;
  localparam int WIN_MC  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwReset = 1'b0;
  logic mcTick = 1'b0;
  logic ctrlWrite = 1'b0;
  logic [CTRL_W-1:0] ctrlWrData = '0;
  logic [NUM_IRQ-1:0] irqPend = '0;
  logic [NUM_IRQ-1:0] irqEn = '0;
  logic irqGlobalEn = 1'b0;
  logic cpuClkEn, periphClkEn, ramWrAllow, portWrAllow, resetSeqActive;
  logic [CTRL_W-1:0] pwrCtrlQ;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  idle_wake_ctrl #(.NUM_IRQ(NUM_IRQ), .CTRL_W(CTRL_W), .WIN_MC(WIN_MC)) u_dut (
    .clk(clk), .rstN(rstN), .hwReset(hwReset), .mcTick(mcTick),
    .ctrlWrite(ctrlWrite), .ctrlWrData(ctrlWrData), .irqPend(irqPend),
    .irqEn(irqEn), .irqGlobalEn(irqGlobalEn), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .ramWrAllow(ramWrAllow), .portWrAllow(portWrAllow),
    .resetSeqActive(resetSeqActive), .pwrCtrlQ(pwrCtrlQ)
  );

  // {pend[3:0], en[3:0], globalEn, expectWake}
  localparam logic [9:0] WAKE_VEC [6] = '{
    {4'b0001, 4'b0001, 1'b1, 1'b1},
    {4'b0001, 4'b0010, 1'b1, 1'b0},
    {4'b0100, 4'b0100, 1'b0, 1'b0},
    {4'b1010, 4'b1000, 1'b1, 1'b1},
    {4'b0000, 4'b1111, 1'b1, 1'b0},
    {4'b1111, 4'b1111, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    mcTick = 1'b1;
    cyc();
    mcTick = 1'b0;
  endtask

  task automatic enterIdle();
    ctrlWrite = 1'b1;
    ctrlWrData = 8'h01;
    cyc();
    ctrlWrite = 1'b0;
    ctrlWrData = '0;
    cyc();
  endtask

  task automatic clearIrq();
    irqPend = '0;
    irqEn = '0;
    irqGlobalEn = 1'b0;
  endtask

  task automatic validIrq();
    irqPend = 4'b0001;
    irqEn = 4'b0001;
    irqGlobalEn = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 periphClkEn", periphClkEn, 1);
    chk("R1 ramWrAllow", ramWrAllow, 1);
    chk("R1 portWrAllow", portWrAllow, 1);
    chk("R1 resetSeqActive", resetSeqActive, 0);
    chk("R1 pwrCtrlQ", pwrCtrlQ, 0);

    // R3: run-time write with idle bit 0 keeps running
    ctrlWrite = 1'b1; ctrlWrData = 8'hFE; cyc();
    ctrlWrite = 1'b0; ctrlWrData = '0; cyc(2);
    chk("R3 write bit0=0 reg", pwrCtrlQ, 32'hFE);
    chk("R3 write bit0=0 running", cpuClkEn, 1);

    // R2: idle entry timing
    ctrlWrite = 1'b1; ctrlWrData = 8'h01; cyc();
    ctrlWrite = 1'b0; ctrlWrData = '0;
    chk("R2 idle bit set", pwrCtrlQ[0], 1);
    chk("R2 cpu still on", cpuClkEn, 1);
    cyc();
    chk("R2 cpu stopped", cpuClkEn, 0);
    chk("R2 periph on", periphClkEn, 1);

    // R3: write while idle is ignored
    ctrlWrite = 1'b1; ctrlWrData = 8'h00; cyc();
    ctrlWrite = 1'b0;
    cyc();
    chk("R3 idle write ignored", pwrCtrlQ[0], 1);
    chk("R3 still idle", cpuClkEn, 0);
    tick(); // no wake source, stays idle
    validIrq(); tick(); clearIrq();
    chk("R5 woken", cpuClkEn, 1);

    // R4/R5 vector table
    foreach (WAKE_VEC[k]) begin
      enterIdle();
      irqPend = WAKE_VEC[k][9:6];
      irqEn = WAKE_VEC[k][5:2];
      irqGlobalEn = WAKE_VEC[k][1];
      tick();
      clearIrq();
      chk($sformatf("R4 vec%0d wake", k), cpuClkEn, WAKE_VEC[k][0]);
      chk($sformatf("R5 vec%0d idle bit", k), pwrCtrlQ[0], !WAKE_VEC[k][0]);
      if (!WAKE_VEC[k][0]) begin
        validIrq(); tick(); clearIrq();
        chk($sformatf("R5 vec%0d recovery", k), cpuClkEn, 1);
      end
    end

    // R5: no tick, no wake
    enterIdle();
    validIrq(); cyc(4);
    chk("R5 no tick stays idle", cpuClkEn, 0);
    tick(); clearIrq();
    chk("R5 tick wakes", cpuClkEn, 1);

    // R6: latched short interrupt
    enterIdle();
    validIrq(); cyc(); clearIrq(); cyc(2);
    chk("R6 idle before tick", cpuClkEn, 0);
    tick();
    chk("R6 latched wake", cpuClkEn, 1);
    chk("R6 idle bit cleared", pwrCtrlQ[0], 0);

    // R7/R8/R9: reset during idle
    enterIdle();
    hwReset = 1'b1; cyc();
    chk("R7 cpu resumes", cpuClkEn, 1);
    chk("R7 ram blocked", ramWrAllow, 0);
    chk("R7 port allowed", portWrAllow, 1);
    chk("R7 idle bit cleared", pwrCtrlQ[0], 0);
    cyc(5);
    chk("R8 no tick, window open", resetSeqActive, 0);
    for (int t = 0; t < WIN_MC - 1; t++) tick();
    chk("R8 window before last tick", resetSeqActive, 0);
    chk("R8 ram still blocked", ramWrAllow, 0);
    tick();
    chk("R8 sequence active", resetSeqActive, 1);
    chk("R8 port blocked", portWrAllow, 0);
    chk("R8 periph off", periphClkEn, 0);
    hwReset = 1'b0; cyc();
    chk("R9 released", resetSeqActive, 0);
    chk("R9 ram allowed", ramWrAllow, 1);
    chk("R9 port allowed", portWrAllow, 1);

    // R10: reset while running
    hwReset = 1'b1; cyc();
    chk("R10 direct sequence", resetSeqActive, 1);
    chk("R10 no window ram", ramWrAllow, 0);
    hwReset = 1'b0; cyc();
    chk("R10 back to run", resetSeqActive, 0);

    // R11: reset beats coincident wake
    enterIdle();
    validIrq(); hwReset = 1'b1; tick(); clearIrq();
    chk("R11 window entered", ramWrAllow, 0);
    chk("R11 cpu on", cpuClkEn, 1);
    for (int t = 0; t < WIN_MC; t++) tick();
    chk("R11 sequence after window", resetSeqActive, 1);
    hwReset = 1'b0; cyc();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule